// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block produces the mailbox interrupts for a memory that two agents share, called side A and side B. Each side has one reserved word near the top of the address space. Side A owns the word one below the highest address, and side B owns the highest address. A write by one side into the other side's word raises that side's interrupt. The owner drops its interrupt by reading its own word. The words themselves hold ordinary user data in the external array, and this block only watches the access controls. The block holds the two interrupt flags, the address match for each side and the set/clear resolution.

A mode input turns the mailbox function on or off. When the mode input is off, both top words are plain storage and the flags are frozen. The address width is a parameter, and both mailbox addresses are derived from it.

All access controls are active low: select, write strobe and output enable. The interrupt outputs are also active low. Every flag change is registered: a qualifying access in one cycle shows at the outputs right after the next rising clock edge.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, both `a_irq_n` and `b_irq_n` go high (inactive).
- R2: If side B presents `b_sel_n`=0, `b_wr_n`=0 and `b_addr` = all-ones minus one at a rising edge with `mbox_en`=1, `a_irq_n` is low after that edge.
- R3: If side A presents `a_sel_n`=0, `a_oe_n`=0 and `a_addr` = all-ones minus one at an edge with `mbox_en`=1, `a_irq_n` is high after that edge, whatever the value of `a_wr_n`, unless R6 applies.
- R4: If side A presents `a_sel_n`=0, `a_wr_n`=0 and `a_addr` = all-ones at an edge with `mbox_en`=1, `b_irq_n` is low after that edge.
- R5: If side B presents `b_sel_n`=0, `b_oe_n`=0 and `b_addr` = all-ones at an edge with `mbox_en`=1, `b_irq_n` is high after that edge, unless R6 applies.
- R6: When a set and a clear of the same flag fall in the same cycle, the flag ends up set (output low).
- R7: While `mbox_en`=0, neither interrupt output changes, whatever the accesses.
- R8: The following leave both flags unchanged:
  - a side writing its own word with `*_oe_n`=1;
  - any access with `*_sel_n`=1;
  - any access to an address other than the two mailbox words.
- R9: The mailbox addresses follow `ADDR_W`. The highest address is all ones in `ADDR_W` bits, and the words below the top two never act as mailboxes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mbox_en | input | 1 | 1 = top two words act as mailboxes |
| a_sel_n | input | 1 | Side A select, active low |
| a_wr_n | input | 1 | Side A write strobe, active low |
| a_oe_n | input | 1 | Side A output enable, active low |
| a_addr | input | ADDR_W | Side A address |
| b_sel_n | input | 1 | Side B select, active low |
| b_wr_n | input | 1 | Side B write strobe, active low |
| b_oe_n | input | 1 | Side B output enable, active low |
| b_addr | input | ADDR_W | Side B address |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
The bench builds the block with `ADDR_W` = 5, so the mailboxes sit at 30 and 31. At that width a random address lands on a mailbox word often, which makes same-cycle set and clear collisions common in the random phase. The bench also drives address 15, which would be the top word at a width of 4, and address 29, just below the lower mailbox. Both must stay inert, which shows that the addresses are derived from the parameter and not fixed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    // Decoded access controls, active high.
    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
    } port_ctl_t;

    // Events one side produces in a cycle.
    typedef struct packed {
        logic own_clr;
        logic peer_set;
    } mbx_evt_t;

    localparam int MAX_AW = 31;

    // Mailbox word owned by a side: A owns top-1, B owns top.
    function automatic logic [MAX_AW-1:0] mbox_addr(input int aw, input side_e s);
        logic [MAX_AW:0] top;
        top = (({{MAX_AW{1'b0}}, 1'b1}) << aw) - 1'b1;
        if (s == SIDE_A) begin
            top = top - 1'b1;
        end
        return top[MAX_AW-1:0];
    endfunction

    function automatic side_e peer_of(input side_e s);
        return (s == SIDE_A) ? SIDE_B : SIDE_A;
    endfunction

    function automatic port_ctl_t decode_ctl(input logic sel_n, input logic wr_n,
                                             input logic oe_n);
        port_ctl_t c;
        c.sel = ~sel_n;
        c.wr  = ~sel_n & ~wr_n;
        c.rd  = ~sel_n & ~oe_n;
        return c;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int    ADDR_W = 12,
    parameter side_e SIDE   = SIDE_A
) (
    input  logic              en,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output mbx_evt_t          evt
);
    localparam logic [ADDR_W-1:0] OWN_ADDR  = ADDR_W'(mbox_addr(ADDR_W, SIDE));
    localparam logic [ADDR_W-1:0] PEER_ADDR = ADDR_W'(mbox_addr(ADDR_W, peer_of(SIDE)));

    port_ctl_t ctl;
    logic      hit_own;
    logic      hit_peer;

    always_comb begin
        ctl      = decode_ctl(sel_n, wr_n, oe_n);
        hit_own  = (addr == OWN_ADDR);
        hit_peer = (addr == PEER_ADDR);
        evt.own_clr  = en & ctl.rd & hit_own;
        evt.peer_set = en & ctl.wr & hit_peer;
    end

    // The two decodes are exclusive because the mailbox addresses differ.
    always_comb begin
        mbx_evt_excl_chk: assert (!(evt.own_clr && evt.peer_set))
            else $error("decode raised both events at once");
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (set) begin
            pend_q <= 1'b1;
        end else if (clr) begin
            pend_q <= 1'b0;
        end
    end

    assign irq_n = ~pend_q;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> !irq_n);

    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> irq_n);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mbox_en,
    input  logic              a_sel_n,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_sel_n,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq_n,
    output logic              b_irq_n
);
    localparam int NSIDE = 2;
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LOW_ADDR = TOP_ADDR - 1'b1;

    logic [NSIDE-1:0]  sel_n_v;
    logic [NSIDE-1:0]  wr_n_v;
    logic [NSIDE-1:0]  oe_n_v;
    logic [ADDR_W-1:0] addr_v [NSIDE];
    mbx_evt_t          evt_v  [NSIDE];
    logic [NSIDE-1:0]  irq_n_v;

    always_comb begin
        sel_n_v   = {b_sel_n, a_sel_n};
        wr_n_v    = {b_wr_n,  a_wr_n};
        oe_n_v    = {b_oe_n,  a_oe_n};
        addr_v[0] = a_addr;
        addr_v[1] = b_addr;
    end

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        mbx_port_decode #(
            .ADDR_W (ADDR_W),
            .SIDE   (side_e'(i))
        ) dec_i (
            .en    (mbox_en),
            .sel_n (sel_n_v[i]),
            .wr_n  (wr_n_v[i]),
            .oe_n  (oe_n_v[i]),
            .addr  (addr_v[i]),
            .evt   (evt_v[i])
        );

        // A flag is raised by the other side's write and dropped by its owner's read.
        mbx_flag flag_i (
            .clk   (clk),
            .rst   (rst),
            .set   (evt_v[NSIDE-1-i].peer_set),
            .clr   (evt_v[i].own_clr),
            .irq_n (irq_n_v[i])
        );
    end

    assign a_irq_n = irq_n_v[0];
    assign b_irq_n = irq_n_v[1];

    // R2
    a_raise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(a_irq_n) |-> $past(mbox_en && !b_sel_n && !b_wr_n && b_addr == LOW_ADDR));

    // R4
    b_raise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(b_irq_n) |-> $past(mbox_en && !a_sel_n && !a_wr_n && a_addr == TOP_ADDR));

    // R5
    b_drop_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(b_irq_n) |-> $past(mbox_en && !b_sel_n && !b_oe_n && b_addr == TOP_ADDR));

    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !mbox_en |=> ($stable(a_irq_n) && $stable(b_irq_n)));

endmodule

// File: tb/mbx_irq_ctrl_tb.sv
module mbx_irq_ctrl_tb_top;
    localparam int AW  = 5;
    localparam int TOP = 31;
    localparam int LOW = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mbox_en = 1'b1;
    logic a_sel_n = 1'b1, a_wr_n = 1'b1, a_oe_n = 1'b1;
    logic b_sel_n = 1'b1, b_wr_n = 1'b1, b_oe_n = 1'b1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_irq_n, b_irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state: 1 = interrupt pending.
    bit ref_a = 0;
    bit ref_b = 0;

    always #2.5 clk = ~clk;

    mbx_irq_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .mbox_en(mbox_en),
        .a_sel_n(a_sel_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
        .b_sel_n(b_sel_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    // Behavioural model written from the requirement list.
    always @(posedge clk) begin
        bit sa, ca, sb, cb;
        sa = mbox_en && b_sel_n == 0 && b_wr_n == 0 && int'(b_addr) == LOW;
        ca = mbox_en && a_sel_n == 0 && a_oe_n == 0 && int'(a_addr) == LOW;
        sb = mbox_en && a_sel_n == 0 && a_wr_n == 0 && int'(a_addr) == TOP;
        cb = mbox_en && b_sel_n == 0 && b_oe_n == 0 && int'(b_addr) == TOP;
        if (rst) begin
            ref_a = 0;
            ref_b = 0;
        end else begin
            if (sa) ref_a = 1; else if (ca) ref_a = 0;
            if (sb) ref_b = 1; else if (cb) ref_b = 0;
        end
    end

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one cycle and compare both outputs against the model.
    task automatic cyc();
        @(negedge clk);
        check_bit("model a_irq_n", a_irq_n, ~ref_a);
        check_bit("model b_irq_n", b_irq_n, ~ref_b);
    endtask

    task automatic idle();
        a_sel_n = 1; a_wr_n = 1; a_oe_n = 1;
        b_sel_n = 1; b_wr_n = 1; b_oe_n = 1;
    endtask

    task automatic acc_a(logic s, logic w, logic o, int ad);
        a_sel_n = s; a_wr_n = w; a_oe_n = o; a_addr = AW'(ad);
    endtask

    task automatic acc_b(logic s, logic w, logic o, int ad);
        b_sel_n = s; b_wr_n = w; b_oe_n = o; b_addr = AW'(ad);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        rst = 1;
        cyc(); cyc();
        check_bit("R1 a reset", a_irq_n, 1'b1);
        check_bit("R1 b reset", b_irq_n, 1'b1);
        rst = 0;

        // R2: B writes A's word.
        acc_b(0, 0, 1, LOW); cyc(); idle();
        check_bit("R2 a set", a_irq_n, 1'b0);
        check_bit("R2 b untouched", b_irq_n, 1'b1);

        // R8: own-word write with oe high, deselected read, B writing its own word.
        acc_a(0, 0, 1, LOW); cyc(); idle();
        check_bit("R8 own write keeps a", a_irq_n, 1'b0);
        acc_a(1, 1, 0, LOW); cyc(); idle();
        check_bit("R8 deselected keeps a", a_irq_n, 1'b0);
        acc_b(0, 0, 1, TOP); cyc(); idle();
        check_bit("R8 b own write", b_irq_n, 1'b1);

        // R3: clear with write strobe low, then again with it high.
        acc_a(0, 0, 0, LOW); cyc(); idle();
        check_bit("R3 clear wr low", a_irq_n, 1'b1);
        acc_b(0, 0, 1, LOW); cyc(); idle();
        acc_a(0, 1, 0, LOW); cyc(); idle();
        check_bit("R3 clear wr high", a_irq_n, 1'b1);

        // R4 / R5
        acc_a(0, 0, 1, TOP); cyc(); idle();
        check_bit("R4 b set", b_irq_n, 1'b0);
        check_bit("R4 a untouched", a_irq_n, 1'b1);
        acc_b(0, 1, 0, TOP); cyc(); idle();
        check_bit("R5 b clear", b_irq_n, 1'b1);

        // R6: set and clear together.
        acc_b(0, 0, 1, LOW); acc_a(0, 1, 0, LOW); cyc(); idle();
        check_bit("R6 a set wins", a_irq_n, 1'b0);
        acc_a(0, 0, 1, TOP); acc_b(0, 1, 0, TOP); cyc(); idle();
        check_bit("R6 b set wins", b_irq_n, 1'b0);

        // R7: frozen while disabled.
        mbox_en = 0;
        acc_a(0, 1, 0, LOW); acc_b(0, 1, 0, TOP); cyc(); idle();
        check_bit("R7 a held low", a_irq_n, 1'b0);
        check_bit("R7 b held low", b_irq_n, 1'b0);
        mbox_en = 1;
        acc_a(0, 1, 0, LOW); acc_b(0, 1, 0, TOP); cyc(); idle();
        mbox_en = 0;
        acc_a(0, 0, 1, TOP); acc_b(0, 0, 1, LOW); cyc(); idle();
        check_bit("R7 a held high", a_irq_n, 1'b1);
        check_bit("R7 b held high", b_irq_n, 1'b1);
        mbox_en = 1;

        // R9: near-miss addresses.
        acc_b(0, 0, 1, 29); acc_a(0, 0, 1, 15); cyc(); idle();
        check_bit("R9 addr 29 inert", a_irq_n, 1'b1);
        check_bit("R9 addr 15 inert", b_irq_n, 1'b1);
        acc_a(0, 0, 1, 0); acc_b(0, 0, 1, 0); cyc(); idle();
        check_bit("R9 addr 0 inert a", a_irq_n, 1'b1);
        check_bit("R9 addr 0 inert b", b_irq_n, 1'b1);

        // Random phase, addresses biased toward the mailbox words.
        for (int n = 0; n < 2000; n++) begin
            int ra, rb;
            ra = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : $urandom_range(29, 31);
            rb = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : $urandom_range(29, 31);
            acc_a(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ra);
            acc_b(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rb);
            mbox_en = ($urandom_range(0, 7) != 0);
            if (n == 1000) rst = 1;
            if (n == 1002) rst = 0;
            cyc();
        end
        idle();
        cyc();
        finish_run();
    end

endmodule